// File: doc/BRIEF.md
# ADC Conversion and Readout Sequencer

This block sits in the FPGA fabric next to an external successive-approximation converter. It paces conversions with a sampling strobe at a fixed rate. It waits for the converter's busy flag to drop, then selects the converter's output port with an active-low read-enable. It then clocks the result in over a serial link, using SPI mode 0 with the most significant bit first. Each finished word is handed to the fabric on a one-cycle valid strobe. The strobe carries the data word, the channel it came from, and the index of the conversion that produced it.

Two output channels are supported. The per-sample channel is read after every conversion. The decimated channel is read only when the converter signals, through an active-low ready flag, that a filtered word is waiting. Every timing margin is a count of system clock cycles fixed at compile time: strobe width, sample period, settle time, select lead and release time, and serial clock divider. If a conversion or read is still in progress when the next period expires, that sample is dropped and a sticky overrun flag is raised.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is held, the sampling strobe and serial clock are low. Both read-enables are high. The valid strobe and the overrun flag are low.
- R2: While `enable` is high, successive rising edges of `smp_clk` are an exact multiple of `PERIOD_CYC` cycles apart, and exactly `PERIOD_CYC` apart when no sample is dropped. While `enable` is low, no new strobe is issued.
- R3: Every `smp_clk` pulse is high for exactly `MCLK_HI_CYC` cycles.
- R4: A read-enable falls only after `cnv_busy` has been seen high and then low, never while the converter is busy.
- R5: On the decimated channel (`chan_sel` = 1), the read-enable `sel_flt_n` falls only when `flt_rdy_n` is low after busy drops. If the flag is high, the conversion ends with no transfer and no word.
- R6: `ser_clk` idles low and toggles only while exactly one read-enable is low. Its first rising edge comes at least `CS_LEAD_CYC` cycles after the read-enable falls. Each high phase lasts `SCK_DIV/2` cycles.
- R7: Each transfer has exactly `WORD_W` rising edges of `ser_clk`. The input bit is captured on each rising edge, and the first bit is the MSB of `word_data`.
- R8: After a read-enable rises, both stay high for at least `CS_TRAIL_CYC` cycles before either falls again.
- R9: When the period expires while the block is not idle, no strobe is issued and `overrun` goes high. It stays high until an `ovr_clr` pulse, and a new overrun in the same cycle as the clear wins.
- R10: `word_valid` is a one-cycle pulse. With it, `word_seq` gives the index of the conversion that produced the word (0 for the first strobe after reset, plus 1 per strobe issued), and `word_chan` gives the channel (0 = per-sample, 1 = decimated).
- R11: `chan_sel` is taken only while the block is idle. A change during a conversion or read affects the next conversion only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new conversions to be paced |
| chan_sel | input | 1 | 0 = per-sample channel, 1 = decimated channel |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| smp_clk | output | 1 | Sampling strobe to the converter |
| cnv_busy | input | 1 | Converter busy flag (asynchronous) |
| flt_rdy_n | input | 1 | Active-low decimated-word ready flag (asynchronous) |
| sel_smp_n | output | 1 | Active-low read-enable, per-sample port |
| sel_flt_n | output | 1 | Active-low read-enable, decimated port |
| ser_clk | output | 1 | Serial clock, shared by both ports |
| ser_din_smp | input | 1 | Serial data from the per-sample port |
| ser_din_flt | input | 1 | Serial data from the decimated port |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_data | output | WORD_W | Captured word |
| word_chan | output | 1 | Channel of the captured word |
| word_seq | output | SEQ_W | Conversion index of the captured word |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
The checks assume the converter raises busy within the strobe width plus the settle count, and holds it high until its conversion is done. They also assume the ready flag falls only when busy falls and stays low until the decimated read-enable rises again, and that serial data changes only after a rising serial clock edge. The bench's behavioural converter meets all of these. It raises busy one cycle after it sees the strobe, keeps it up for a programmable number of cycles, and asserts ready on every fourth conversion while the decimated channel is selected. The only time it breaks the pacing budget is when its conversion time is deliberately stretched past one period to provoke an overrun.

// File: rtl/adc_rd_pkg.sv
// Shared types for the ADC readout sequencer.
package adc_rd_pkg;
    // Sequencer phases, in the order a normal sample walks through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_CONV,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } seq_state_t;

    // Converter output port being read.
    typedef enum logic {
        CH_SAMPLE = 1'b0,
        CH_FILTER = 1'b1
    } chan_t;
endpackage

// File: rtl/adc_rd_sync.sv
// Multi-stage synchronizer for asynchronous converter flags.
// Assumes each input bit is quasi-static relative to clk; it adds
// STAGES cycles of latency and is reset to RST_VAL.
module adc_rd_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            // Later stages: pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/adc_rd_pacer.sv
// Sample-period timer. Raises tick for one cycle every PERIOD_CYC
// cycles while enable is high; holds its count at zero otherwise.
// Assumes PERIOD_CYC >= 2.
module adc_rd_pacer #(
    parameter int PERIOD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int PW = $clog2(PERIOD_CYC + 1);
    localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);

    logic [PW-1:0] cnt_q;

    // Free-running period count, cleared whenever pacing is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = enable && (cnt_q == LAST);
endmodule

// File: rtl/adc_rd_shifter.sv
// SPI mode 0 receive engine. On start it produces WORD_W serial clock
// periods of SCK_DIV system cycles each, beginning with a low phase.
// It captures sdi MSB first on each rising edge and pulses done on
// the edge that returns the serial clock low after the last bit.
// Assumes SCK_DIV is even and >= 2, WORD_W >= 2, and start is only
// pulsed while idle.
module adc_rd_shifter #(
    parameter int WORD_W  = 32,
    parameter int SCK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sdi,
    output logic              sck,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int HALF  = SCK_DIV / 2;
    localparam int PH_W  = $clog2(HALF + 1);
    localparam int BIT_W = $clog2(WORD_W + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    logic              run_q;
    logic              sck_q;
    logic              done_q;
    logic [PH_W-1:0]   ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] shreg_q;

    // Phase timing, clock toggling, bit capture and end-of-word pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
            ph_q    <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                run_q <= 1'b1;
                sck_q <= 1'b0;
                ph_q  <= '0;
                bit_q <= '0;
            end else if (run_q) begin
                if (ph_q == PH_LAST) begin
                    ph_q  <= '0;
                    sck_q <= ~sck_q;
                    if (!sck_q) begin
                        shreg_q <= {shreg_q[WORD_W-2:0], sdi};
                    end else if (bit_q == BIT_LAST) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign sck  = sck_q;
    assign done = done_q;
    assign word = shreg_q;
endmodule

// File: rtl/adc_readout_ctrl.sv
// ADC conversion and readout sequencer (top).
// Paces sampling strobes, waits out the converter's busy flag, gates
// decimated reads on the ready flag, and frames each serial transfer
// with read-enable lead and release margins. All margins are counted
// in system clock cycles. Assumes MCLK_HI_CYC, BUSY_SETTLE_CYC,
// CS_LEAD_CYC and CS_TRAIL_CYC are >= 1 and that busy becomes visible
// through the synchronizer within MCLK_HI_CYC + BUSY_SETTLE_CYC cycles.
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int WORD_W          = 32,
    parameter int SEQ_W           = 16,
    parameter int PERIOD_CYC      = 250,
    parameter int MCLK_HI_CYC     = 4,
    parameter int BUSY_SETTLE_CYC = 4,
    parameter int CS_LEAD_CYC     = 4,
    parameter int CS_TRAIL_CYC    = 3,
    parameter int SCK_DIV         = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              chan_sel,
    input  logic              ovr_clr,
    output logic              smp_clk,
    input  logic              cnv_busy,
    input  logic              flt_rdy_n,
    output logic              sel_smp_n,
    output logic              sel_flt_n,
    output logic              ser_clk,
    input  logic              ser_din_smp,
    input  logic              ser_din_flt,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              word_chan,
    output logic [SEQ_W-1:0]  word_seq,
    output logic              overrun
);
    localparam int MAX_AB = (MCLK_HI_CYC > BUSY_SETTLE_CYC) ? MCLK_HI_CYC : BUSY_SETTLE_CYC;
    localparam int MAX_CD = (CS_LEAD_CYC > CS_TRAIL_CYC) ? CS_LEAD_CYC : CS_TRAIL_CYC;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HI_LAST    = CW'(MCLK_HI_CYC - 1);
    localparam logic [CW-1:0] SETTLE     = CW'(BUSY_SETTLE_CYC);
    localparam logic [CW-1:0] LEAD_LAST  = CW'(CS_LEAD_CYC - 1);
    localparam logic [CW-1:0] TRAIL_LAST = CW'(CS_TRAIL_CYC - 1);

    seq_state_t        st_q;
    chan_t             act_chan_q;
    logic [CW-1:0]     cnt_q;
    logic              smp_clk_q;
    logic              sel_smp_n_q;
    logic              sel_flt_n_q;
    logic              ovr_q;
    logic [SEQ_W-1:0]  seq_cnt_q;
    logic [SEQ_W-1:0]  seq_cur_q;
    logic              wv_q;
    logic [WORD_W-1:0] wd_q;
    logic              wc_q;
    logic [SEQ_W-1:0]  ws_q;

    logic              tick;
    logic [1:0]        flags_s;
    logic              busy_s;
    logic              rdy_n_s;
    logic              sh_start;
    logic              sh_done;
    logic              sh_sdi;
    logic [WORD_W-1:0] sh_word;

    adc_rd_pacer #(
        .PERIOD_CYC(PERIOD_CYC)
    ) pacer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .tick  (tick)
    );

    adc_rd_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) flag_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({flt_rdy_n, cnv_busy}),
        .q    (flags_s)
    );

    assign busy_s  = flags_s[0];
    assign rdy_n_s = flags_s[1];

    assign sh_start = (st_q == ST_LEAD) && (cnt_q == LEAD_LAST);
    assign sh_sdi   = (act_chan_q == CH_FILTER) ? ser_din_flt : ser_din_smp;

    adc_rd_shifter #(
        .WORD_W (WORD_W),
        .SCK_DIV(SCK_DIV)
    ) shifter_i (
        .clk  (clk),
        .rst_n(rst_n),
        .start(sh_start),
        .sdi  (sh_sdi),
        .sck  (ser_clk),
        .done (sh_done),
        .word (sh_word)
    );

    // Main sequencer: strobe, conversion wait, select lead, shift, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            act_chan_q  <= CH_SAMPLE;
            cnt_q       <= '0;
            smp_clk_q   <= 1'b0;
            sel_smp_n_q <= 1'b1;
            sel_flt_n_q <= 1'b1;
            seq_cnt_q   <= '0;
            seq_cur_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    act_chan_q <= chan_t'(chan_sel);
                    if (tick) begin
                        st_q      <= ST_STROBE;
                        smp_clk_q <= 1'b1;
                        cnt_q     <= '0;
                        seq_cur_q <= seq_cnt_q;
                        seq_cnt_q <= seq_cnt_q + 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt_q == HI_LAST) begin
                        smp_clk_q <= 1'b0;
                        cnt_q     <= '0;
                        st_q      <= ST_CONV;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cnt_q < SETTLE) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (!busy_s) begin
                        cnt_q <= '0;
                        if (act_chan_q == CH_SAMPLE) begin
                            sel_smp_n_q <= 1'b0;
                            st_q        <= ST_LEAD;
                        end else if (!rdy_n_s) begin
                            sel_flt_n_q <= 1'b0;
                            st_q        <= ST_LEAD;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_LEAD: begin
                    if (sh_start) st_q  <= ST_SHIFT;
                    else          cnt_q <= cnt_q + 1'b1;
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        sel_smp_n_q <= 1'b1;
                        sel_flt_n_q <= 1'b1;
                        cnt_q       <= '0;
                        st_q        <= ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (cnt_q == TRAIL_LAST) st_q  <= ST_IDLE;
                    else                     cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Word hand-off: one-cycle strobe with data, channel and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wv_q <= 1'b0;
            wd_q <= '0;
            wc_q <= 1'b0;
            ws_q <= '0;
        end else begin
            wv_q <= 1'b0;
            if (st_q == ST_SHIFT && sh_done) begin
                wv_q <= 1'b1;
                wd_q <= sh_word;
                wc_q <= act_chan_q;
                ws_q <= seq_cur_q;
            end
        end
    end

    // Sticky overrun: set on a period expiry outside idle, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovr_q <= 1'b0;
        else if (tick && st_q != ST_IDLE) ovr_q <= 1'b1;
        else if (ovr_clr)               ovr_q <= 1'b0;
    end

    assign smp_clk    = smp_clk_q;
    assign sel_smp_n  = sel_smp_n_q;
    assign sel_flt_n  = sel_flt_n_q;
    assign word_valid = wv_q;
    assign word_data  = wd_q;
    assign word_chan  = wc_q;
    assign word_seq   = ws_q;
    assign overrun    = ovr_q;
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
// Protocol checker for adc_readout_ctrl, bound to every instance.
// Tracks pulse widths and gaps with its own counters.
module adc_readout_ctrl_chk #(
    parameter int PERIOD_CYC   = 250,
    parameter int MCLK_HI_CYC  = 4,
    parameter int CS_LEAD_CYC  = 4,
    parameter int CS_TRAIL_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic smp_clk,
    input logic sel_smp_n,
    input logic sel_flt_n,
    input logic ser_clk,
    input logic word_valid,
    input logic overrun,
    input logic ovr_clr
);
    logic sel_low;
    logic smp_d, sel_d, sck_d;
    logic seen_rise, seen_rel;
    int   hi_cnt, gap_cnt, low_cnt, rel_cnt;

    assign sel_low = !sel_smp_n || !sel_flt_n;

    // Edge history and width/gap counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_d <= 1'b0; sel_d <= 1'b0; sck_d <= 1'b0;
            seen_rise <= 1'b0; seen_rel <= 1'b0;
            hi_cnt <= 0; gap_cnt <= 0; low_cnt <= 0; rel_cnt <= 0;
        end else begin
            smp_d   <= smp_clk;
            sel_d   <= sel_low;
            sck_d   <= ser_clk;
            hi_cnt  <= smp_clk ? hi_cnt + 1 : 0;
            low_cnt <= sel_low ? low_cnt + 1 : 0;
            rel_cnt <= sel_low ? 0 : rel_cnt + 1;
            if (smp_clk && !smp_d) begin
                gap_cnt   <= 1;
                seen_rise <= 1'b1;
            end else begin
                gap_cnt <= gap_cnt + 1;
            end
            if (sel_d && !sel_low) seen_rel <= 1'b1;
        end
    end

    // R2
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_clk && !smp_d && seen_rise) |-> gap_cnt >= PERIOD_CYC);
    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_clk && smp_d) |-> hi_cnt == MCLK_HI_CYC);
    // R6
    sck_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> sel_low);
    // R6
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_smp_n && !sel_flt_n));
    // R6
    select_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !sck_d) |-> low_cnt >= CS_LEAD_CYC);
    // R8
    select_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_low && !sel_d && seen_rel) |-> rel_cnt >= CS_TRAIL_CYC);
    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
    .PERIOD_CYC  (PERIOD_CYC),
    .MCLK_HI_CYC (MCLK_HI_CYC),
    .CS_LEAD_CYC (CS_LEAD_CYC),
    .CS_TRAIL_CYC(CS_TRAIL_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_clk   (smp_clk),
    .sel_smp_n (sel_smp_n),
    .sel_flt_n (sel_flt_n),
    .ser_clk   (ser_clk),
    .word_valid(word_valid),
    .overrun   (overrun),
    .ovr_clr   (ovr_clr)
);

// File: tb/adc_readout_ctrl_tb_top.sv
// Bench: behavioural converter model, expected-word queue and per-clock
// timing monitor for adc_readout_ctrl.
module adc_readout_ctrl_tb_top;
    localparam int W      = 16;
    localparam int SW     = 16;
    localparam int PERIOD = 140;
    localparam int HI     = 4;
    localparam int LEAD   = 4;
    localparam int TRAIL  = 3;
    localparam int DIV    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic chan_sel = 1'b0;
    logic ovr_clr = 1'b0;
    logic smp_clk, sel_smp_n, sel_flt_n, ser_clk;
    logic cnv_busy, flt_rdy_n;
    logic ser_din_smp, ser_din_flt;
    logic word_valid, word_chan, overrun;
    logic [W-1:0]  word_data;
    logic [SW-1:0] word_seq;

    always #2.5 clk = ~clk;

    adc_readout_ctrl #(
        .WORD_W(W), .SEQ_W(SW), .PERIOD_CYC(PERIOD), .MCLK_HI_CYC(HI),
        .BUSY_SETTLE_CYC(4), .CS_LEAD_CYC(LEAD), .CS_TRAIL_CYC(TRAIL),
        .SCK_DIV(DIV), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chan_sel(chan_sel),
        .ovr_clr(ovr_clr), .smp_clk(smp_clk), .cnv_busy(cnv_busy),
        .flt_rdy_n(flt_rdy_n), .sel_smp_n(sel_smp_n), .sel_flt_n(sel_flt_n),
        .ser_clk(ser_clk), .ser_din_smp(ser_din_smp), .ser_din_flt(ser_din_flt),
        .word_valid(word_valid), .word_data(word_data), .word_chan(word_chan),
        .word_seq(word_seq), .overrun(overrun)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] val_smp(input int k);
        return W'(32'hA5C3 ^ (k * 32'h03B1));
    endfunction
    function automatic logic [W-1:0] val_flt(input int k);
        return W'(32'h5E17 + (k * 32'h0C05));
    endfunction

    // ---------------- converter model ----------------
    int conv_cyc = 40;
    int conv_idx = 0;
    int cur_k = 0;
    int btimer = 0;
    bit cur_ch = 1'b0;
    bit m_prev_smp = 1'b0;
    bit m_prev_flt = 1'b1;
    logic [W-1:0] word_s = '0;
    logic [W-1:0] word_f = '0;
    logic [W+SW:0] exp_q[$];

    // Busy timing, ready flag and result words, one conversion at a time.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnv_busy  <= 1'b0;
            flt_rdy_n <= 1'b1;
            m_prev_smp = 1'b0;
            m_prev_flt = 1'b1;
            btimer     = 0;
        end else begin
            if (sel_flt_n && !m_prev_flt) flt_rdy_n <= 1'b1;
            if (smp_clk && !m_prev_smp) begin
                cur_k = conv_idx;
                conv_idx++;
                cur_ch = chan_sel;
                cnv_busy <= 1'b1;
                btimer = conv_cyc;
            end else if (btimer > 0) begin
                btimer--;
                if (btimer == 0) begin
                    cnv_busy <= 1'b0;
                    word_s   <= val_smp(cur_k);
                    if (!cur_ch) begin
                        exp_q.push_back({1'b0, SW'(cur_k), val_smp(cur_k)});
                    end else if (cur_k % 4 == 3) begin
                        flt_rdy_n <= 1'b0;
                        word_f    <= val_flt(cur_k);
                        exp_q.push_back({1'b1, SW'(cur_k), val_flt(cur_k)});
                    end
                end
            end
            m_prev_smp = smp_clk;
            m_prev_flt = sel_flt_n;
        end
    end

    // Serial output: bit index advances after each rising serial clock.
    wire sel_idle = sel_smp_n & sel_flt_n;
    int bit_idx = 0;
    always @(posedge ser_clk or posedge sel_idle) begin
        if (sel_idle) bit_idx <= 0;
        else          bit_idx <= bit_idx + 1;
    end
    assign ser_din_smp = (bit_idx < W) ? word_s[W-1-bit_idx] : 1'b0;
    assign ser_din_flt = (bit_idx < W) ? word_f[W-1-bit_idx] : 1'b0;

    // ---------------- per-clock monitor ----------------
    int  cyc = 0;
    int  last_rise = -1;
    int  hi_len = 0;
    int  sck_hi = 0;
    int  sel_low_len = 0;
    int  rel_len = 0;
    bit  seen_rel = 1'b0;
    int  rises_in_read = 0;
    int  rise_count = 0;
    int  double_gaps = 0;
    int  words_seen = 0;
    bit  p_smp = 1'b0, p_sck = 1'b0, p_ss = 1'b1, p_sf = 1'b1, p_wv = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            cyc++;
            // R2 / R3: strobe spacing and width
            if (smp_clk && !p_smp) begin
                rise_count++;
                if (last_rise >= 0) begin
                    chk((cyc - last_rise) == PERIOD || (cyc - last_rise) == 2 * PERIOD,
                        "R2", "strobe spacing", cyc - last_rise, PERIOD);
                    if ((cyc - last_rise) == 2 * PERIOD) double_gaps++;
                end
                last_rise = cyc;
            end
            if (smp_clk) hi_len++;
            if (!smp_clk && p_smp) begin
                chk(hi_len == HI, "R3", "strobe width", hi_len, HI);
                hi_len = 0;
            end
            // R6: select exclusivity and serial clock gating
            if (!sel_smp_n && !sel_flt_n) chk(1'b0, "R6", "both selects low", 0, 1);
            if (ser_clk && sel_idle) chk(1'b0, "R6", "serial clock without select", 1, 0);
            // R4 / R5 / R8: select falling edge conditions
            if ((!sel_smp_n && p_ss) || (!sel_flt_n && p_sf)) begin
                chk(cnv_busy == 1'b0, "R4", "busy at select fall", cnv_busy, 0);
                if (seen_rel) chk(rel_len >= TRAIL, "R8", "release gap", rel_len, TRAIL);
                rises_in_read = 0;
            end
            if (!sel_flt_n && p_sf)
                chk(flt_rdy_n == 1'b0, "R5", "ready flag at decimated select", flt_rdy_n, 0);
            if (!sel_idle) sel_low_len++;
            else           sel_low_len = 0;
            // R6 lead and high phase, R7 bit count
            if (ser_clk && !p_sck) begin
                rises_in_read++;
                if (rises_in_read == 1)
                    chk(sel_low_len > LEAD, "R6", "lead before first rise", sel_low_len, LEAD);
            end
            if (ser_clk) sck_hi++;
            if (!ser_clk && p_sck) begin
                chk(sck_hi == DIV / 2, "R6", "serial clock high phase", sck_hi, DIV / 2);
                sck_hi = 0;
            end
            if (sel_idle && !(p_ss & p_sf)) begin
                chk(rises_in_read == W, "R7", "rising edges per word", rises_in_read, W);
                seen_rel = 1'b1;
                rel_len = 0;
            end
            if (sel_idle) rel_len++;
            // R7 / R10: word contents against the expected queue
            if (word_valid) begin
                words_seen++;
                chk(!p_wv, "R10", "valid lasts one cycle", p_wv, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected word", word_data, 0);
                end else begin
                    logic [W+SW:0] e;
                    e = exp_q.pop_front();
                    chk(word_data == e[W-1:0], "R7", "word data", word_data, e[W-1:0]);
                    chk(word_seq == e[W+SW-1:W], "R10", "word index", word_seq, e[W+SW-1:W]);
                    chk(word_chan == e[W+SW], "R11", "word channel", word_chan, e[W+SW]);
                end
            end
            p_smp = smp_clk; p_sck = ser_clk; p_ss = sel_smp_n; p_sf = sel_flt_n;
            p_wv = word_valid;
        end
    end

    task automatic report_and_finish();
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R2", "watchdog expired", 0, 1);
        report_and_finish();
    end

    task automatic wait_words(input int target);
        while (words_seen < target) @(negedge clk);
    endtask

    initial begin
        int base;
        int rc;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(smp_clk == 1'b0, "R1", "strobe in reset", smp_clk, 0);
        chk(sel_smp_n && sel_flt_n, "R1", "selects in reset", {sel_smp_n, sel_flt_n}, 3);
        chk(ser_clk == 1'b0, "R1", "serial clock in reset", ser_clk, 0);
        chk(word_valid == 1'b0, "R1", "valid in reset", word_valid, 0);
        chk(overrun == 1'b0, "R1", "overrun in reset", overrun, 0);
        rst_n = 1'b1;
        enable = 1'b1;

        // Per-sample channel, several conversions
        wait_words(5);

        // R11: switch channel mid-read; the current word stays per-sample
        while (sel_smp_n) @(negedge clk);
        chan_sel = 1'b1;
        base = words_seen;
        wait_words(base + 4);
        chk(conv_idx >= 16, "R5", "decimated words need several conversions", conv_idx, 16);

        // Back to per-sample between conversions
        chan_sel = 1'b0;
        base = words_seen;
        wait_words(base + 2);

        // R9: stretch one conversion past the period
        conv_cyc = 150;
        while (!overrun) @(negedge clk);
        conv_cyc = 40;
        chk(overrun == 1'b1, "R9", "overrun raised", overrun, 1);
        repeat (300) @(negedge clk);
        chk(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);
        chk(double_gaps == 1, "R9", "dropped strobe leaves double gap", double_gaps, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R9", "overrun cleared", overrun, 0);

        // R2: disable stops new strobes
        base = words_seen;
        wait_words(base + 1);
        enable = 1'b0;
        rc = rise_count;
        repeat (3 * PERIOD) @(negedge clk);
        chk(rise_count == rc, "R2", "no strobe while disabled", rise_count - rc, 0);
        chk(exp_q.size() == 0, "R10", "all expected words delivered", exp_q.size(), 0);
        report_and_finish();
    end
endmodule